// File: doc/BRIEF.md
# Overwriting Circular FIFO

A first-in first-out store for fixed-width words. It holds its words in a small register file that has two circular address pointers over it. Both pointers come from one address-generator module, instantiated twice. The write port takes a word on every cycle that a write is requested. The read port shows the oldest stored word combinationally, and a read request pops that word.

A separate occupancy counter gives the fill level and the registered full and empty flags. The counter is kept in step with the distance between the pointers. A read request while the store is empty is ignored.

A write into a full store is still accepted. In that case the oldest word is discarded, and the read pointer moves forward together with the write pointer. The newest data therefore always wins, and the level stays at the maximum.

Top module: `ovw_ring_fifo`

## Requirements
- R1: During and right after a synchronous active-high reset, `empty` is 1, `full` is 0 and `level` is 0.
- R2: Words leave in the order they were written. While `empty` is 0, `rd_data` shows the oldest stored word in the same cycle, with no clock edge in between.
- R3: `level` never exceeds DEPTH (16). `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R4: From one cycle to the next, `level` stays the same, rises by 1 or falls by 1. The only other change is a return to 0 on reset.
- R5: `level` equals the write address minus the read address, with DEPTH added when the write address is the smaller of the two. The full state is the one exception: there the difference is 0 and `level` is DEPTH.
- R6: A read request while `empty` is 1 has no effect. With no write in the same cycle, `level` stays 0 and `empty` stays 1.
- R7: A write into a full store with no read request drops the oldest word. The read address advances by one, `level` stays at DEPTH, and the next word shown is the one written second oldest.
- R8: A write and a read in the same cycle on a full store pop the oldest word and append the new one, and `level` stays at DEPTH.
- R9: An effective read (read request while not empty) changes the read address on the next cycle. With no read request and the store not full, the read address and `rd_data` hold their values.
- R10: Each pointer goes from the last location (DEPTH-1) back to 0, so ordering is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request. Always accepted; overwrites the oldest word when the store is full |
| wr_data | input | 8 | Word to store |
| rd_req | input | 1 | Read request (pop the oldest word). Ignored when empty |
| rd_data | output | 8 | Oldest stored word, combinational from the read address |
| full | output | 1 | Registered flag: level equals DEPTH |
| empty | output | 1 | Registered flag: level is 0 |
| level | output | 5 | Number of stored words, from 0 to DEPTH |

## Verification
The main function is driven with four kinds of input pattern, and each one separates a different kind of fault.

- Plain fill-then-drain sequences expose ordering faults and wrong flags at the two ends of the range.
- Writes into a full store with no read isolate the skip path. A design that blocks the write, or that forgets to move the read pointer, shows the wrong word next.
- A write and a read together on a full store, and a read together with a write on an empty store, tell the simultaneous paths apart from the overwrite and ignore paths.
- A long stretch of seeded random requests crosses many pointer wraps and a mid-run reset. It catches wrong wrap points and level drift against a queue model.

// File: rtl/ovw_pkg.sv
package ovw_pkg;

  // Kind of access decoded for the current cycle
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_SWAP  = 3'd3,   // pop and push together
    OP_OVWR  = 3'd4    // push into full store, oldest dropped
  } op_e;

endpackage

// File: rtl/ovw_addr_gen.sv
module ovw_addr_gen #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (step) begin
      addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/ovw_regfile.sv
module ovw_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Synchronous write, no reset on the array
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous read
  assign rdata = mem[raddr];

endmodule

// File: rtl/ovw_occupancy.sv
module ovw_occupancy
  import ovw_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic [CW-1:0] lvl_q, lvl_d;
  logic          full_q, empty_q;

  always_comb begin
    unique case (op)
      OP_PUSH: lvl_d = lvl_q + 1'b1;
      OP_POP:  lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;   // idle, swap and overwrite keep the level
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      lvl_q   <= lvl_d;
      full_q  <= (lvl_d == TOP);
      empty_q <= (lvl_d == '0);
    end
  end

  assign level = lvl_q;
  assign full  = full_q;
  assign empty = empty_q;

endmodule

// File: rtl/ovw_ring_fifo.sv
module ovw_ring_fifo
  import ovw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     level
);

  logic [AW-1:0] waddr, raddr;
  logic          rd_eff, skip, rptr_step;
  op_e           op;

  assign rd_eff    = rd_req & ~empty;
  assign skip      = full & wr_req & ~rd_req;
  assign rptr_step = rd_eff | skip;

  always_comb begin
    if (skip)                op = OP_OVWR;
    else if (wr_req & rd_eff) op = OP_SWAP;
    else if (wr_req)         op = OP_PUSH;
    else if (rd_eff)         op = OP_POP;
    else                     op = OP_IDLE;
  end

  ovw_addr_gen #(.DEPTH(DEPTH)) u_wptr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_req),
    .addr (waddr)
  );

  ovw_addr_gen #(.DEPTH(DEPTH)) u_rptr (
    .clk  (clk),
    .rst  (rst),
    .step (rptr_step),
    .addr (raddr)
  );

  ovw_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_req),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  ovw_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .level (level),
    .full  (full),
    .empty (empty)
  );

endmodule

// File: rtl/ovw_ring_fifo_chk.sv
module ovw_ring_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_req,
  input logic          rd_req,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] level,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr
);

  int ptr_diff;
  assign ptr_diff = (waddr >= raddr) ? int'(waddr) - int'(raddr)
                                     : int'(waddr) + DEPTH - int'(raddr);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  assert_full_flag_R3: assert property (@(posedge clk) disable iff (rst)
    full == (int'(level) == DEPTH));

  assert_empty_flag_R3: assert property (@(posedge clk) disable iff (rst)
    empty == (level == '0));

  assert_level_step_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(level) == int'($past(level)) ||
              int'(level) == int'($past(level)) + 1 ||
              int'(level) == int'($past(level)) - 1));

  assert_level_matches_ptrs_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(level) == ptr_diff) || (int'(level) == DEPTH && ptr_diff == 0));

  assert_empty_read_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req && !wr_req) |=> (empty && $stable(raddr)));

  assert_skip_on_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_req) |=> (full && raddr != $past(raddr)));

  assert_full_swap_keeps_full_R8: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && rd_req) |=> full);

  assert_read_moves_raddr_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !empty) |=> raddr != $past(raddr));

  assert_raddr_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !full) |=> $stable(raddr));

  assert_waddr_wraps_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_req && int'(waddr) == DEPTH - 1) |=> waddr == '0);

  assert_raddr_wraps_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !empty && int'(raddr) == DEPTH - 1) |=> raddr == '0);

endmodule

bind ovw_ring_fifo ovw_ring_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_req (wr_req),
  .rd_req (rd_req),
  .full   (full),
  .empty  (empty),
  .level  (level),
  .waddr  (waddr),
  .raddr  (raddr)
);

// File: tb/tb_ovw_ring_fifo.sv
`timescale 1ns/1ps
module tb_ovw_ring_fifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_req = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              full, empty;
  logic [CW-1:0]     level;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] model [$];
  int prev_level = 0;

  always #2 clk = ~clk;

  ovw_ring_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk (clk), .rst (rst), .wr_req (wr_req), .wr_data (wr_data),
    .rd_req (rd_req), .rd_data (rd_data), .full (full), .empty (empty),
    .level (level)
  );

  // Expected level after one cycle, from the requirements
  function automatic int next_level(int lvl, bit wr, bit rd);
    bit rd_ok = rd && (lvl > 0);
    if (wr && !rd_ok) return (lvl == DEPTH) ? DEPTH : lvl + 1;
    if (!wr && rd_ok) return lvl - 1;
    return lvl;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    int n = model.size();
    check("R5 level", int'(level) == n, int'(level), n);
    check("R3 full",  full == (n == DEPTH), int'(full), int'(n == DEPTH));
    check("R3 empty", empty == (n == 0), int'(empty), int'(n == 0));
    check("R4 step",  (int'(level) - prev_level) inside {-1, 0, 1},
          int'(level), prev_level);
    if (n > 0) check(tag, rd_data == model[0], int'(rd_data), int'(model[0]));
    prev_level = int'(level);
  endtask

  task automatic step(bit wr, bit rd, logic [DATA_W-1:0] d, string tag);
    int exp_lvl;
    bit rd_ok;
    @(negedge clk);
    wr_req = wr; rd_req = rd; wr_data = d;
    exp_lvl = next_level(model.size(), wr, rd);
    rd_ok = rd && (model.size() > 0);
    @(posedge clk);
    if (rd_ok) void'(model.pop_front());
    if (wr) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back(d);
    end
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    check("R4 model", model.size() == exp_lvl, model.size(), exp_lvl);
    check_outputs(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model.delete();
    check("R1 empty", empty == 1'b1, int'(empty), 1);
    check("R1 full",  full == 1'b0, int'(full), 0);
    check("R1 level", level == '0, int'(level), 0);
    rst = 1'b0;
    prev_level = 0;
  endtask

  initial begin
    logic [DATA_W-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    do_reset();

    // R6: read on empty is ignored
    step(1'b0, 1'b1, 8'h00, "R6");
    check("R6 empty held", empty == 1'b1 && level == '0, int'(level), 0);
    // read with write on empty: write lands, read ignored
    step(1'b1, 1'b1, 8'hA5, "R6");
    step(1'b0, 1'b1, 8'h00, "R2");

    // fill to full, in order
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 8'(8'h10 + i), "R2");
    check("R3 full reached", full == 1'b1, int'(full), 1);

    // R7: overwrite oldest with no read
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'(8'hE0 + i), "R7");
    check("R7 oldest dropped", rd_data == 8'h13, int'(rd_data), 8'h13);

    // R8: full, write and read together
    step(1'b1, 1'b1, 8'hC3, "R8");
    check("R8 still full", full == 1'b1, int'(full), 1);

    // R9: idle keeps the shown word
    held = rd_data;
    step(1'b0, 1'b0, 8'hFF, "R9");
    check("R9 rd_data held", rd_data == held, int'(rd_data), int'(held));

    // drain fully, order across the wrap
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00, "R10");
    check("R6 drained", empty == 1'b1, int'(empty), 1);
    step(1'b0, 1'b1, 8'h00, "R6");

    // constrained random with a mid-run reset
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 99) < 55);
      bit r = ($urandom_range(0, 99) < 45);
      if (i == 1500) do_reset();
      step(w, r, 8'($urandom), "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4ns * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule